// File: doc/BRIEF.md
# Dual Vectored Interrupt Generator

This block serves an 8-bit CPU that takes its interrupts in vectored mode 0, where the interrupting device supplies a one-byte restart opcode during the acknowledge cycle. From the 12 MHz master clock it derives a one-in-four clock enable, which gives the 3 MHz CPU rate. It issues two interrupts on a single active-low request line in every 60 Hz video frame.

The first request is raised on the rising edge of the vertical blank input. The CPU's service routine for it lives at restart 10h. The second request is raised a fixed number of CPU clock enables later. The default is 9900, which is about 3.3 ms, and its service routine lives at restart 08h. Each request stays pending until the CPU runs an acknowledge cycle, which is M1 and IORQ both low. At the start of that cycle the block picks the vector to serve and clears the matching pending flag. It then drives the opcode on an 8-bit vector bus, and an output enable marks the bus as driven for the length of the cycle. If the delayed request falls due while the vblank request is still waiting, it is queued behind it.

Top module: `dual_rst_irq`

## Requirements
- R1: `cpuClkEn` is high for exactly one master cycle in every `CLK_DIV` (default 4) master cycles, and never on two cycles in a row.
- R2: While reset is held, and right after it is released, `intN` is high and `vecOe` is low.
- R3: A rising edge on `vblank` pulls `intN` low on the next master cycle. Keeping `vblank` high raises no further request.
- R4: The first acknowledge cycle after a vblank request places opcode D7h (restart 10h) on `vecData`.
- R5: The delayed request falls due once `DELAY_TICKS` CPU clock enables have passed since the registered vblank edge. `intN` goes low one master cycle after the enable that completes the count. Its acknowledge places opcode CFh (restart 08h) on `vecData`.
- R6: A pending request keeps `intN` low until an acknowledge cycle begins. The request it serves is cleared at the start of that cycle.
- R7: If both requests are pending, the vblank one (D7h) is served first. The delayed one stays pending, so `intN` stays low, and the next acknowledge serves it (CFh).
- R8: `vecOe` rises one master cycle after M1 and IORQ are both seen low. It falls one master cycle after either of them returns high. `vecData` holds its value while `vecOe` is high.
- R9: An acknowledge cycle with nothing pending places FFh on `vecData` and leaves `intN` high.
- R10: A new vblank edge that arrives before the delayed request is due restarts the delay count from that edge, and only one delayed request results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 12 MHz master clock |
| rstN | input | 1 | Asynchronous reset, active low |
| vblank | input | 1 | Vertical blank level from the video timing |
| m1N | input | 1 | CPU machine-cycle-one strobe, active low |
| iorqN | input | 1 | CPU I/O request strobe, active low |
| cpuClkEn | output | 1 | One-in-CLK_DIV clock enable for the CPU |
| intN | output | 1 | Interrupt request to the CPU, active low |
| vecData | output | 8 | Restart opcode for the current acknowledge cycle |
| vecOe | output | 1 | High while `vecData` is being driven onto the CPU bus |

## Verification
Corruption in the pending flags shows up on `intN` within one master cycle. The line either stays low after the only pending request has been acknowledged, or it stays high after a vblank edge, and the next acknowledge then returns the wrong opcode. A delay counter that is off by even one enable moves the second falling edge of `intN` by `CLK_DIV` master cycles. The bench counts enables at the ports and brackets that edge exactly. A fault in the acknowledge edge detector shows up one cycle later, as `vecOe` failing to follow the strobes or `vecData` changing in the middle of a cycle.

// File: rtl/intr_pkg.sv
package intr_pkg;

  localparam logic [7:0] VecVblank = 8'hD7;  // restart 10h
  localparam logic [7:0] VecDelay  = 8'hCF;  // restart 08h
  localparam logic [7:0] VecNone   = 8'hFF;  // spurious acknowledge

  typedef struct packed {
    logic clkEn;      // CPU clock enable this cycle
    logic vbRise;     // vblank rising edge seen
    logic secondDue;  // delayed request falls due
    logic ackStart;   // first cycle of an acknowledge
    logic ackNow;     // acknowledge strobes active now
  } ctrlStrobes_t;

endpackage

// File: rtl/intr_ctrl.sv
module intr_ctrl
  import intr_pkg::*;
#(
  parameter int CLK_DIV     = 4,
  parameter int DELAY_TICKS = 9900
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         vblank,
  input  logic         m1N,
  input  logic         iorqN,
  output ctrlStrobes_t strobes
);

  localparam int DIV_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int DLY_W = $clog2(DELAY_TICKS + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
  localparam logic [DLY_W-1:0] DLY_LOAD = DLY_W'(DELAY_TICKS);
  localparam logic [DLY_W-1:0] DLY_ONE  = DLY_W'(1);

  logic [DIV_W-1:0] divCnt;
  logic [DLY_W-1:0] dlyCnt;
  logic             dlyArmed;
  logic             vbQ;
  logic             ackQ;
  logic             clkEnNow;
  logic             vbRiseNow;
  logic             ackNowC;

  assign clkEnNow  = (divCnt == DIV_LAST);
  assign vbRiseNow = vblank & ~vbQ;
  assign ackNowC   = ~m1N & ~iorqN;

  // clock-enable divider
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (clkEnNow) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + DIV_W'(1);
    end
  end

  // edge detectors
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vbQ  <= 1'b0;
      ackQ <= 1'b0;
    end else begin
      vbQ  <= vblank;
      ackQ <= ackNowC;
    end
  end

  // delay counter in CPU clock enables, restarted by every vblank edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dlyCnt   <= '0;
      dlyArmed <= 1'b0;
    end else if (vbRiseNow) begin
      dlyCnt   <= DLY_LOAD;
      dlyArmed <= 1'b1;
    end else if (dlyArmed && clkEnNow) begin
      dlyCnt <= dlyCnt - DLY_ONE;
      if (dlyCnt == DLY_ONE) begin
        dlyArmed <= 1'b0;
      end
    end
  end

  always_comb begin
    strobes.clkEn     = clkEnNow;
    strobes.vbRise    = vbRiseNow;
    strobes.secondDue = dlyArmed & clkEnNow & (dlyCnt == DLY_ONE) & ~vbRiseNow;
    strobes.ackStart  = ackNowC & ~ackQ;
    strobes.ackNow    = ackNowC;
  end

endmodule

// File: rtl/intr_datapath.sv
module intr_datapath
  import intr_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strobes,
  output logic         intN,
  output logic [7:0]   vecData,
  output logic         vecOe
);

  logic pendFirst;
  logic pendSecond;

  // pending flags: a set in the same cycle as a clear wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendFirst  <= 1'b0;
      pendSecond <= 1'b0;
    end else begin
      if (strobes.ackStart) begin
        if (pendFirst) begin
          pendFirst <= 1'b0;
        end else if (pendSecond) begin
          pendSecond <= 1'b0;
        end
      end
      if (strobes.vbRise) begin
        pendFirst <= 1'b1;
      end
      if (strobes.secondDue) begin
        pendSecond <= 1'b1;
      end
    end
  end

  // vector chosen once, at the start of the acknowledge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecData <= VecNone;
      vecOe   <= 1'b0;
    end else begin
      vecOe <= strobes.ackNow;
      if (strobes.ackStart) begin
        if (pendFirst) begin
          vecData <= VecVblank;
        end else if (pendSecond) begin
          vecData <= VecDelay;
        end else begin
          vecData <= VecNone;
        end
      end
    end
  end

  assign intN = ~(pendFirst | pendSecond);

endmodule

// File: rtl/dual_rst_irq.sv
module dual_rst_irq
  import intr_pkg::*;
#(
  parameter int CLK_DIV     = 4,
  parameter int DELAY_TICKS = 9900
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       vblank,
  input  logic       m1N,
  input  logic       iorqN,
  output logic       cpuClkEn,
  output logic       intN,
  output logic [7:0] vecData,
  output logic       vecOe
);

  ctrlStrobes_t strobes;

  intr_ctrl #(
    .CLK_DIV    (CLK_DIV),
    .DELAY_TICKS(DELAY_TICKS)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .vblank (vblank),
    .m1N    (m1N),
    .iorqN  (iorqN),
    .strobes(strobes)
  );

  intr_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .intN   (intN),
    .vecData(vecData),
    .vecOe  (vecOe)
  );

  assign cpuClkEn = strobes.clkEn;

endmodule

// File: rtl/dual_rst_irq_chk.sv
module dual_rst_irq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       vblank,
  input logic       m1N,
  input logic       iorqN,
  input logic       cpuClkEn,
  input logic       intN,
  input logic [7:0] vecData,
  input logic       vecOe
);

  AST_CLKEN_GAP: assert property (@(posedge clk) disable iff (!rstN) cpuClkEn |=> !cpuClkEn); // R1
  AST_VBLANK_RAISES: assert property (@(posedge clk) disable iff (!rstN) $rose(vblank) |=> !intN); // R3
  AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rstN) (!intN && !(!m1N && !iorqN)) |=> !intN); // R6
  AST_OE_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rstN) vecOe |-> $past(!m1N && !iorqN)); // R8
  AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rstN) !(!m1N && !iorqN) |=> !vecOe); // R8
  AST_VEC_STABLE: assert property (@(posedge clk) disable iff (!rstN) (vecOe && !m1N && !iorqN) |=> $stable(vecData)); // R8
  AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (!rstN) vecOe |-> (vecData == 8'hD7 || vecData == 8'hCF || vecData == 8'hFF)); // R4

endmodule

bind dual_rst_irq dual_rst_irq_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .vblank  (vblank),
  .m1N     (m1N),
  .iorqN   (iorqN),
  .cpuClkEn(cpuClkEn),
  .intN    (intN),
  .vecData (vecData),
  .vecOe   (vecOe)
);

// File: tb/dual_rst_irq_tb.sv
`timescale 1ns/1ps
module dual_rst_irq_tb;

  localparam int DIV = 4;
  localparam int DLY = 50;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       vblank = 1'b0;
  logic       m1N = 1'b1;
  logic       iorqN = 1'b1;
  logic       cpuClkEn;
  logic       intN;
  logic [7:0] vecData;
  logic       vecOe;

  int checks = 0;
  int fails = 0;
  int enCount = 0;
  int enBase = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dual_rst_irq #(.CLK_DIV(DIV), .DELAY_TICKS(DLY)) u_dut (
    .clk(clk), .rstN(rstN), .vblank(vblank), .m1N(m1N), .iorqN(iorqN),
    .cpuClkEn(cpuClkEn), .intN(intN), .vecData(vecData), .vecOe(vecOe)
  );

  function automatic int elapsed();
    return enCount - enBase;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (cpuClkEn) enCount++;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic waitElapsed(input int target);
    while (elapsed() < target) tick();
  endtask

  task automatic raiseVblank(input int hold);
    vblank = 1'b1;
    enBase = enCount;
    tick();
    check(intN == 1'b0, "R3 request after vblank edge", intN, 0);
    ticks(hold);
    vblank = 1'b0;
  endtask

  task automatic ackCycle(input logic [7:0] expVec, input string req);
    m1N = 1'b0;
    iorqN = 1'b0;
    tick();
    check(vecOe == 1'b1, "R8 output enable during ack", vecOe, 1);
    tick();
    check(vecData == expVec, req, vecData, expVec);
    m1N = 1'b1;
    iorqN = 1'b1;
    tick();
    check(vecOe == 1'b0, "R8 output enable released", vecOe, 0);
  endtask

  initial begin
    #(1_000_000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int nEn;
    bit twoInRow;
    bit prevEn;
    void'($urandom(32'd20240611));
    ticks(3);
    check(intN == 1'b1 && vecOe == 1'b0, "R2 reset state", {intN, vecOe}, 2'b10);
    rstN = 1'b1;
    tick();
    check(intN == 1'b1 && vecOe == 1'b0, "R2 after reset", {intN, vecOe}, 2'b10);

    // R1 divider
    nEn = 0;
    twoInRow = 1'b0;
    prevEn = 1'b0;
    for (int i = 0; i < 10 * DIV; i++) begin
      tick();
      if (cpuClkEn) nEn++;
      if (cpuClkEn && prevEn) twoInRow = 1'b1;
      prevEn = cpuClkEn;
    end
    check(nEn == 10, "R1 enable count", nEn, 10);
    check(!twoInRow, "R1 no adjacent enables", twoInRow, 0);

    // R9 spurious acknowledge
    ackCycle(8'hFF, "R9 spurious vector");
    check(intN == 1'b1, "R9 no request after spurious ack", intN, 1);

    // R3/R5 exact timing, vblank held high throughout
    vblank = 1'b1;
    enBase = enCount;
    tick();
    check(intN == 1'b0, "R3 request after vblank edge", intN, 0);
    ticks(5);
    check(intN == 1'b0, "R6 request held without ack", intN, 0);
    ackCycle(8'hD7, "R4 vblank vector");
    check(intN == 1'b1, "R3 held vblank raises nothing", intN, 1);
    while (elapsed() < DLY) begin
      tick();
      if (elapsed() < DLY) check(intN == 1'b1, "R5 not yet due", intN, 1);
    end
    check(intN == 1'b1, "R5 high at last enable", intN, 1);
    tick();
    check(intN == 1'b0, "R5 due after delay", intN, 0);
    vblank = 1'b0;
    ackCycle(8'hCF, "R5 delayed vector");
    check(intN == 1'b1, "R6 cleared by ack", intN, 1);
    ackCycle(8'hFF, "R9 nothing left");

    // R10 restart by a second edge
    raiseVblank(2);
    waitElapsed(DLY / 2);
    raiseVblank(2);
    ackCycle(8'hD7, "R10 one vblank vector");
    ticks(DLY / 2 * DIV + 2 * DIV);
    check(intN == 1'b1, "R10 delay restarted", intN, 1);
    waitElapsed(DLY + 1);
    tick();
    check(intN == 1'b0, "R10 delayed after restart", intN, 0);
    ackCycle(8'hCF, "R10 delayed vector");
    ackCycle(8'hFF, "R10 single delayed request");

    // random frames: ack latency may cross the delay (R7 queueing)
    for (int f = 0; f < 12; f++) begin
      int wait1;
      raiseVblank($urandom_range(1, 20));
      wait1 = $urandom_range(0, DLY * DIV + 60);
      ticks(wait1);
      ackCycle(8'hD7, "R7 vblank served first");
      if (elapsed() >= DLY + 1)
        check(intN == 1'b0, "R7 delayed stays pending", intN, 0);
      else if (elapsed() < DLY)
        check(intN == 1'b1, "R5 delayed not yet due", intN, 1);
      waitElapsed(DLY + 1);
      tick();
      check(intN == 1'b0, "R5 delayed pending", intN, 0);
      ticks($urandom_range(0, 30));
      check(intN == 1'b0, "R6 still pending", intN, 0);
      ackCycle(8'hCF, "R7 delayed served second");
      check(intN == 1'b1, "R6 idle after both", intN, 1);
      ticks($urandom_range(5, 40));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule